// File: doc/BRIEF.md
# Reseeded Stop-and-Go Keystream Engine

This block produces a keystream one bit at a time for a stream cipher that XORs the keystream onto a data stream. Three linear feedback shift registers form a clock-controlled generator. A control register chooses, on each step, which of two data registers advances. The keystream bit is the XOR of the outputs of those two data registers. Generated bits go into a small output FIFO. The data path pulls bits from the FIFO at its own pace, so the generator runs ahead of the data and stalls when the FIFO is full.

A slow background random source fills a seed buffer, one bit per valid strobe. At each frame boundary, typically once per video frame, the block takes the whole seed word and reloads all three register states from it. It also loads new feedback tap masks, picked from a computed table by a small select field of the same word. The output FIFO is flushed at that boundary, so no bit from the previous frame reaches the data path. If too few seed bits are present when the frame starts, the block raises an underflow flag and delivers nothing until the buffer is full. It then reloads without needing another frame pulse.

Top module: `ks_stopgo_engine`

## Requirements
- R1: After reset, ks_valid, seed_underflow and seed_full are low, and no keystream bit appears until a reload has happened.
- R2: The seed buffer collects SEED_NEED = SEL_W+LEN_A+LEN_B+LEN_C bits. The k-th bit accepted lands at bit k of the seed word, counting the first bit accepted as k = 0. seed_full is high once all SEED_NEED bits are held. Strobes that arrive while the buffer is full are ignored.
- R3: The seed word is split into fields, from bit 0 upward: the select field sel (SEL_W bits), then the state of register A, then B, then C. The tap mask of each register is its base mask XOR (sel shifted left by one). The base masks are A = 0x50000001, B = 0x1000000021 and C = 0x14000001.
- R4: Every register advances the same way: feedback = XOR of (state AND taps), and next state = {feedback, state[LEN-1:1]}. The register's output bit is state[0].
- R5: Each generation step emits A.out XOR B.out, computed from the current states. The step then advances C, and also advances A if C.out is 1, or B if C.out is 0.
- R6: A frame_start pulse while seed_full is high reloads all three states and tap masks and empties the seed buffer. Generation resumes after that.
- R7: A frame_start pulse discards every buffered keystream bit, so ks_valid is low in the cycle that follows it.
- R8: A frame_start pulse while seed_full is low sets seed_underflow and holds ks_valid low. The reload happens in the cycle after the buffer becomes full, and seed_underflow then drops.
- R9: A register whose state field in the seed word is all zeros is loaded with the value 1.
- R10: ks_bit is meaningful while ks_valid is high, and ks_rd removes that bit. Bits are delivered in generation order, and none is lost when the reader pauses: generation stalls while the OBUF_DEPTH-entry FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle frame boundary pulse |
| seed_valid | input | 1 | Seed bit strobe from the background source |
| seed_bit | input | 1 | Seed bit |
| ks_rd | input | 1 | Take the current keystream bit |
| ks_bit | output | 1 | Keystream bit at the FIFO head |
| ks_valid | output | 1 | FIFO holds at least one bit |
| seed_underflow | output | 1 | Waiting for seed bits to finish a reload |
| seed_full | output | 1 | Seed buffer holds a complete reload word |

## Verification
The assertions assume that inputs are low while reset is applied. They also assume that frame_start is a single-cycle pulse and that no seed strobe coincides with the reload cycle, where such a bit would be dropped. The stimulus changes every input on the falling clock edge. It keeps frame pulses to one cycle and never feeds seed bits during a frame pulse. The bench works out expected keystream bits from the field layout, tap formula and stepping rule alone. It compares every delivered bit in order, including after long read pauses, flushes, underflow waits and all-zero fields.

// File: rtl/ks_stopgo_pkg.sv
package ks_stopgo_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_RUN  = 2'd2
  } ks_phase_e;
endpackage

// File: rtl/ks_lfsr_seg.sv
module ks_lfsr_seg #(
  parameter int LEN = 31
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [LEN-1:0] load_state,
  input  logic [LEN-1:0] load_taps,
  input  logic           step,
  output logic           out_bit
);
  localparam logic [LEN-1:0] ZERO_FILL = LEN'(1);

  logic [LEN-1:0] state_q, state_d;
  logic [LEN-1:0] taps_q, taps_d;

  always_comb begin
    state_d = state_q;
    taps_d  = taps_q;
    if (load) begin
      state_d = (load_state == '0) ? ZERO_FILL : load_state;
      taps_d  = load_taps;
    end else if (step) begin
      state_d = {^(state_q & taps_q), state_q[LEN-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      taps_q  <= '0;
    end else begin
      state_q <= state_d;
      taps_q  <= taps_d;
    end
  end

  assign out_bit = state_q[0];

  assert_load_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> (state_q != '0));
endmodule

// File: rtl/ks_seed_buf.sv
module ks_seed_buf #(
  parameter int NEED = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seed_valid,
  input  logic            seed_bit,
  input  logic            take,
  output logic [NEED-1:0] word,
  output logic            full
);
  localparam int CW = $clog2(NEED + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(NEED);

  logic [NEED-1:0] word_q, word_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (take) begin
      cnt_d = '0;
    end else if (seed_valid && (cnt_q != CNT_FULL)) begin
      word_d = {seed_bit, word_q[NEED-1:1]};
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  assign word = word_q;
  assign full = (cnt_q == CNT_FULL);

  assert_seed_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  assert_seed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(full) && !$past(take)) |-> $stable(word_q));
endmodule

// File: rtl/ks_bit_fifo.sv
module ks_bit_fifo #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic push,
  input  logic push_bit,
  input  logic pop,
  output logic head_bit,
  output logic not_empty,
  output logic full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_MAX = (AW+1)'(DEPTH);

  logic [DEPTH-1:0] mem_q;
  logic [AW-1:0]    rd_q, rd_d, wr_q, wr_d;
  logic [AW:0]      cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full      = (cnt_q == CNT_MAX);
  assign not_empty = (cnt_q != '0);
  assign do_push   = push && !full && !flush;
  assign do_pop    = pop && not_empty && !flush;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = wr_q + AW'(1);
      if (do_pop)  rd_d = rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + (AW+1)'(1);
        2'b01:   cnt_d = cnt_q - (AW+1)'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (do_push) begin
      mem_q[wr_q] <= push_bit;
    end
  end

  assign head_bit = mem_q[rd_q];

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !not_empty);
endmodule

// File: rtl/ks_stopgo_engine.sv
module ks_stopgo_engine
  import ks_stopgo_pkg::*;
#(
  parameter int              LEN_A      = 31,
  parameter int              LEN_B      = 37,
  parameter int              LEN_C      = 29,
  parameter int              SEL_W      = 3,
  parameter int              OBUF_DEPTH = 8,
  parameter logic [LEN_A-1:0] BASE_A    = 31'h5000_0001,
  parameter logic [LEN_B-1:0] BASE_B    = 37'h10_0000_0021,
  parameter logic [LEN_C-1:0] BASE_C    = 29'h1400_0001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic seed_valid,
  input  logic seed_bit,
  input  logic ks_rd,
  output logic ks_bit,
  output logic ks_valid,
  output logic seed_underflow,
  output logic seed_full
);
  localparam int SEED_NEED = SEL_W + LEN_A + LEN_B + LEN_C;
  localparam int OFS_A     = SEL_W;
  localparam int OFS_B     = OFS_A + LEN_A;
  localparam int OFS_C     = OFS_B + LEN_B;

  ks_phase_e phase_q, phase_d;
  logic [SEED_NEED-1:0] seed_word;
  logic [SEL_W-1:0]     sel;
  logic [LEN_A-1:0]     taps_a;
  logic [LEN_B-1:0]     taps_b;
  logic [LEN_C-1:0]     taps_c;
  logic                 reload, gen, fifo_full;
  logic                 a_out, b_out, c_out;

  ks_seed_buf #(.NEED(SEED_NEED)) i_seed (
    .clk(clk), .rst_n(rst_n), .seed_valid(seed_valid), .seed_bit(seed_bit),
    .take(reload), .word(seed_word), .full(seed_full)
  );

  assign sel    = seed_word[SEL_W-1:0];
  assign taps_a = BASE_A ^ (LEN_A'(sel) << 1);
  assign taps_b = BASE_B ^ (LEN_B'(sel) << 1);
  assign taps_c = BASE_C ^ (LEN_C'(sel) << 1);

  always_comb begin
    reload  = seed_full && (frame_start || (phase_q == PH_WAIT));
    phase_d = phase_q;
    if (reload)           phase_d = PH_RUN;
    else if (frame_start) phase_d = PH_WAIT;
    gen = (phase_q == PH_RUN) && !frame_start && !fifo_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  ks_lfsr_seg #(.LEN(LEN_A)) i_reg_a (
    .clk(clk), .rst_n(rst_n), .load(reload),
    .load_state(seed_word[OFS_A +: LEN_A]), .load_taps(taps_a),
    .step(gen && c_out), .out_bit(a_out)
  );

  ks_lfsr_seg #(.LEN(LEN_B)) i_reg_b (
    .clk(clk), .rst_n(rst_n), .load(reload),
    .load_state(seed_word[OFS_B +: LEN_B]), .load_taps(taps_b),
    .step(gen && !c_out), .out_bit(b_out)
  );

  ks_lfsr_seg #(.LEN(LEN_C)) i_reg_c (
    .clk(clk), .rst_n(rst_n), .load(reload),
    .load_state(seed_word[OFS_C +: LEN_C]), .load_taps(taps_c),
    .step(gen), .out_bit(c_out)
  );

  ks_bit_fifo #(.DEPTH(OBUF_DEPTH)) i_obuf (
    .clk(clk), .rst_n(rst_n), .flush(frame_start), .push(gen),
    .push_bit(a_out ^ b_out), .pop(ks_rd), .head_bit(ks_bit),
    .not_empty(ks_valid), .full(fifo_full)
  );

  assign seed_underflow = (phase_q == PH_WAIT);

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start) |-> !ks_valid);
  assert_wait_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seed_underflow |-> !ks_valid);
  assert_wait_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_underflow && seed_full && !frame_start) |=> !seed_underflow);
  assert_reload_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reload) |-> !seed_full);
endmodule

// File: tb/test_ks_stopgo_engine.sv
module test_ks_stopgo_engine;
  localparam int LA = 31, LB = 37, LC = 29, SW = 3, DEPTH = 8;
  localparam logic [LA-1:0] TA = 31'h5000_0001;
  localparam logic [LB-1:0] TB = 37'h10_0000_0021;
  localparam logic [LC-1:0] TC = 29'h1400_0001;

  localparam int NV = 4;
  localparam logic [99:0] SEEDS [NV] = '{
    100'h3A5C19F2E0B7D44681C3BE95A,
    100'hC1D2E3F405162738495A6B7C3,
    100'h7FFEEDDCCBBAA998877665547,
    100'h00123456789ABCDEF0FEDCBA8
  };
  localparam int PAUSE [NV] = '{0, 30, 3, 0};
  localparam int NBITS [NV] = '{40, 40, 32, 48};

  logic clk = 1'b0;
  logic rst_n;
  logic frame_start, seed_valid, seed_bit, ks_rd;
  logic ks_bit, ks_valid, seed_underflow, seed_full;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [LA-1:0] ma, ta;
  logic [LB-1:0] mb, tb;
  logic [LC-1:0] mc, tc;

  always #10 clk = ~clk;

  ks_stopgo_engine #(
    .LEN_A(LA), .LEN_B(LB), .LEN_C(LC), .SEL_W(SW), .OBUF_DEPTH(DEPTH),
    .BASE_A(TA), .BASE_B(TB), .BASE_C(TC)
  ) i_ks_stopgo_engine (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .seed_valid(seed_valid), .seed_bit(seed_bit), .ks_rd(ks_rd),
    .ks_bit(ks_bit), .ks_valid(ks_valid),
    .seed_underflow(seed_underflow), .seed_full(seed_full)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // R3, R9: expected register contents from the seed word
  task automatic model_load(input logic [99:0] s);
    logic [SW-1:0] sl;
    sl = s[2:0];
    ma = s[33:3];
    mb = s[70:34];
    mc = s[99:71];
    if (ma == '0) ma = LA'(1);
    if (mb == '0) mb = LB'(1);
    if (mc == '0) mc = LC'(1);
    ta = TA ^ (LA'(sl) << 1);
    tb = TB ^ (LB'(sl) << 1);
    tc = TC ^ (LC'(sl) << 1);
  endtask

  // R4, R5: one generation step
  task automatic model_next(output logic b);
    logic cb;
    b  = ma[0] ^ mb[0];
    cb = mc[0];
    mc = {^(mc & tc), mc[LC-1:1]};
    if (cb) ma = {^(ma & ta), ma[LA-1:1]};
    else    mb = {^(mb & tb), mb[LB-1:1]};
  endtask

  task automatic feed_seed(input logic [99:0] s);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      seed_valid = 1'b1;
      seed_bit   = s[i];
    end
    @(negedge clk);
    seed_valid = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic read_check(input int n, input string req);
    int got   = 0;
    int guard = 0;
    logic eb;
    while (got < n && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (ks_valid) begin
        model_next(eb);
        check(ks_bit == eb, req, ks_bit, eb);
        ks_rd = 1'b1;
        got++;
      end else begin
        ks_rd = 1'b0;
      end
    end
    @(negedge clk);
    ks_rd = 1'b0;
    check(got == n, {req, " bit count"}, got, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    frame_start = 1'b0;
    seed_valid = 1'b0;
    seed_bit = 1'b0;
    ks_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    check(ks_valid == 1'b0, "R1 ks_valid", ks_valid, 0);
    check(seed_underflow == 1'b0, "R1 seed_underflow", seed_underflow, 0);
    check(seed_full == 1'b0, "R1 seed_full", seed_full, 0);
    repeat (10) @(negedge clk);
    check(ks_valid == 1'b0, "R1 no output before reload", ks_valid, 0);

    // Vector walk: R2 R3 R4 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      feed_seed(SEEDS[v]);
      check(seed_full == 1'b1, "R2 seed_full after fill", seed_full, 1);
      pulse_frame();
      @(negedge clk);
      check(seed_full == 1'b0, "R6 buffer emptied by reload", seed_full, 0);
      model_load(SEEDS[v]);
      repeat (PAUSE[v]) @(negedge clk);
      read_check(NBITS[v], "R5 R10 keystream vector");
    end

    // R7: old bits discarded at a frame boundary
    repeat (20) @(negedge clk);
    feed_seed(100'h55555AAAA3333CCCC0F0FF0F5);
    pulse_frame();
    check(ks_valid == 1'b0, "R7 flushed after frame", ks_valid, 0);
    model_load(100'h55555AAAA3333CCCC0F0FF0F5);
    read_check(24, "R7 new frame bits");

    // R8: frame with empty seed buffer
    pulse_frame();
    check(seed_underflow == 1'b1, "R8 underflow raised", seed_underflow, 1);
    repeat (10) @(negedge clk);
    check(ks_valid == 1'b0, "R8 no output while waiting", ks_valid, 0);
    check(seed_underflow == 1'b1, "R8 underflow held", seed_underflow, 1);
    feed_seed(100'h987654321_0FEDCBA987654326);
    @(negedge clk);
    check(seed_underflow == 1'b0, "R8 underflow cleared", seed_underflow, 0);
    model_load(100'h987654321_0FEDCBA987654326);
    read_check(24, "R8 bits after late reload");

    // R9: all-zero A and C fields
    begin
      logic [99:0] sz;
      sz = {29'b0, 37'h1_2345_6789, 31'b0, 3'b100};
      feed_seed(sz);
      pulse_frame();
      model_load(sz);
      read_check(32, "R9 zero field replaced");
    end

    // R2: strobes beyond a full buffer ignored
    feed_seed(SEEDS[1]);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      seed_valid = 1'b1;
      seed_bit   = 1'b1;
    end
    @(negedge clk);
    seed_valid = 1'b0;
    check(seed_full == 1'b1, "R2 still full", seed_full, 1);
    pulse_frame();
    model_load(SEEDS[1]);
    read_check(24, "R2 extra seed bits ignored");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule